// File: doc/BRIEF.md
# Flash Write-Buffer Command Sequencer

This block decodes the bus write cycles that reach a parallel NOR-style flash device and runs the command sequences that change its contents. A write cycle is presented on `we_i`, `addr_i` and `wdata_i` and is taken at a rising clock edge. The main sequence is the buffered program. A setup command is followed by a count cycle that gives N. Then come N+1 data cycles, which fill an internal buffer, and finally a confirm code. Only a confirm that arrives on exactly the cycle after the last data cycle hands the buffer to the write state machine. The write state machine is modelled as a sequencer that copies one buffer entry per cycle into a small register-file array and then waits out a fixed settle time.

The block also handles single-word program, per-block lock setting and a global lock clear. A status register records sequence errors, program errors and lock violations. Reads are combinational from the current read mode: array, status, or extended status. While the write state machine is busy, a read returns only the ready bit. The other data lines are reported as undriven through an output-enable mask.

Top module: `flash_wbuf_cui`

## Requirements
- R1: After reset the block is in array-read mode, every array word reads FFFFh, no block is locked, and the status register reads 80h (ready, no error bits).
- R2: Command E8h switches reads to extended status, which reads 0080h (bit 7 = buffer available). The next write gives the count N. The following N+1 writes store address/data pairs. A D0h on the next write programs all of them into the array and switches reads to status mode. Locations outside those N+1 addresses are unchanged.
- R3: On the cycle after the (N+1)th data cycle, any code other than D0h aborts the sequence. The abort sets status bits 5 and 4 and leaves the array unchanged. A D0h value given during a data cycle is stored as data and does not end the sequence.
- R4: In word mode (`word_mode_i`=1) the count limit is 000Fh. In byte mode it is 1Fh. A larger count aborts the sequence and sets status bit 4 only. The write after it is decoded as a command, not loaded as data. The maximum count in each mode is accepted.
- R5: Only `wdata_i[7:0]` is decoded for command writes in either mode. In byte mode only the low byte of the count and of each data cycle is used. A byte-mode program replaces the low byte of the target word and keeps its upper byte. Array reads in byte mode return the low byte on bits 7:0.
- R6: Both 40h and 10h start a single-word program. The next write stores its data at its address.
- R7: While the write state machine is busy, `rdata_oe_o` is 0080h and bit 7 reads 0. Bus writes are ignored during this time.
- R8: 60h followed by 01h locks the block selected by the upper `BLK_W` address bits. A program or confirmed buffered program whose target block is locked is rejected. The rejection sets status bits 4 and 1, and the array is unchanged.
- R9: 60h followed by D0h clears the lock bit of every block in one operation.
- R10: 70h selects status reads and FFh selects array reads. 50h clears status bits 5, 4 and 1 and returns to array reads. When not busy, `rdata_oe_o` is FFFFh in word mode and 00FFh in byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Bus write cycle strobe, sampled at the rising edge |
| addr_i | input | AW | Word address for writes and reads |
| wdata_i | input | 16 | Write data / command code |
| word_mode_i | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| rdata_o | output | 16 | Read data for the current read mode |
| rdata_oe_o | output | 16 | Per-bit drive enable of the read data |

## Verification
The bench checks confirm placement from both sides. A D0h value sits inside the data cycles and must be stored, and a wrong code sits in the confirm slot. An off-by-one counter would either program early or accept the wrong code. Counts are tried at and just past the limit in both modes. A wrong limit would load a 17th word or reject a legal 32-byte transfer. Lock checks cover rejection of both program paths and the single-shot clear. Busy checks confirm that a write issued mid-program cannot change the read mode, which a design that fails to gate writes would allow.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;
  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_WBUF     = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_PGM_A    = 8'h40;
  localparam logic [7:0] CMD_PGM_B    = 8'h10;
  localparam logic [7:0] CMD_LOCK     = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET = 8'h01;

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_DATA, S_CONF, S_PGM, S_LOCK} cui_st_e;
  typedef enum logic [1:0] {RM_ARRAY, RM_STAT, RM_XSR} rmode_e;
endpackage

// File: rtl/fcu_buffer.sv
module fcu_buffer #(
  parameter int AW    = 6,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [15:0]   wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [15:0]   rd_data_o
);
  logic [AW-1:0] addr_mem [DEPTH];
  logic [15:0]   data_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      addr_mem[wr_idx_i] <= wr_addr_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_addr_o = addr_mem[rd_idx_i];
  assign rd_data_o = data_mem[rd_idx_i];
endmodule

// File: rtl/fcu_wsm.sv
module fcu_wsm #(
  parameter int IW  = 5,
  parameter int LAT = 4,
  localparam int LW = $clog2(LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] last_i,
  output logic          busy_o,
  output logic          wr_en_o,
  output logic [IW-1:0] idx_o
);
  typedef enum logic [1:0] {W_IDLE, W_PROG, W_SETTLE} wsm_ph_e;
  wsm_ph_e       ph_q;
  logic [IW-1:0] idx_q, last_q;
  logic [LW-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= W_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      wait_q <= '0;
    end else begin
      unique case (ph_q)
        W_IDLE: if (start_i) begin
          ph_q   <= W_PROG;
          idx_q  <= '0;
          last_q <= last_i;
        end
        W_PROG: begin
          if (idx_q == last_q) begin
            ph_q   <= W_SETTLE;
            wait_q <= LW'(LAT - 1);
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        W_SETTLE: begin
          if (wait_q == '0) ph_q <= W_IDLE;
          else              wait_q <= wait_q - 1'b1;
        end
        default: ph_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o  = (ph_q != W_IDLE);
  assign wr_en_o = (ph_q == W_PROG);
  assign idx_o   = idx_q;

  AST_WSM_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> idx_q <= last_q); // R2
  AST_WSM_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i); // R7
endmodule

// File: rtl/fcu_array.sv
module fcu_array #(
  parameter int AW    = 6,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [15:0]   wdata_i,
  input  logic          byte_only_i,
  input  logic [AW-1:0] raddr_i,
  output logic [15:0]   rdata_o
);
  logic [15:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= 16'hFFFF;
    end else if (we_i) begin
      mem_q[waddr_i][7:0] <= wdata_i[7:0];
      if (!byte_only_i) mem_q[waddr_i][15:8] <= wdata_i[15:8];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/flash_wbuf_cui.sv
module flash_wbuf_cui
  import flash_cui_pkg::*;
#(
  parameter int AW        = 6,
  parameter int BLK_W     = 2,
  parameter int MAX_WORDS = 16,
  parameter int LAT       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  input  logic          word_mode_i,
  output logic [15:0]   rdata_o,
  output logic [15:0]   rdata_oe_o
);
  localparam int DEPTH = 2 * MAX_WORDS;
  localparam int IW    = $clog2(DEPTH);
  localparam int NBLK  = 1 << BLK_W;

  cui_st_e          st_q;
  rmode_e           rmode_q;
  logic             sr_seq_q, sr_pgm_q, sr_lck_q;
  logic [NBLK-1:0]  lock_q;
  logic [IW-1:0]    idx_q, last_q;
  logic [BLK_W-1:0] blk_q;
  logic             bmode_q;

  logic [7:0]       cmd;
  logic [15:0]      cnt_val, cnt_max;
  logic             cnt_ok, eff_we, wsm_busy, wsm_wr, wsm_start, buf_we;
  logic [BLK_W-1:0] blk_a;
  logic [IW-1:0]    wsm_idx, buf_idx;
  logic [AW-1:0]    buf_raddr;
  logic [15:0]      buf_rdata, arr_rdata;
  logic [7:0]       sr;

  assign cmd     = wdata_i[7:0];
  assign blk_a   = addr_i[AW-1 -: BLK_W];
  assign eff_we  = we_i & ~wsm_busy;
  assign cnt_val = word_mode_i ? wdata_i : {8'h00, wdata_i[7:0]};
  assign cnt_max = word_mode_i ? 16'(MAX_WORDS - 1) : 16'(DEPTH - 1);
  assign cnt_ok  = (cnt_val <= cnt_max);

  assign buf_we    = eff_we & ((st_q == S_DATA) | (st_q == S_PGM));
  assign buf_idx   = (st_q == S_PGM) ? '0 : idx_q;
  assign wsm_start = eff_we & (((st_q == S_CONF) & (cmd == CMD_CONFIRM) & ~lock_q[blk_q]) |
                               ((st_q == S_PGM) & ~lock_q[blk_a]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      rmode_q  <= RM_ARRAY;
      sr_seq_q <= 1'b0;
      sr_pgm_q <= 1'b0;
      sr_lck_q <= 1'b0;
      lock_q   <= '0;
      idx_q    <= '0;
      last_q   <= '0;
      blk_q    <= '0;
      bmode_q  <= 1'b0;
    end else if (eff_we) begin
      unique case (st_q)
        S_IDLE: begin
          unique case (cmd)
            CMD_WBUF: begin
              st_q    <= S_CNT;
              rmode_q <= RM_XSR;
              blk_q   <= blk_a;
              bmode_q <= ~word_mode_i;
            end
            CMD_PGM_A, CMD_PGM_B: begin
              st_q    <= S_PGM;
              rmode_q <= RM_STAT;
              bmode_q <= ~word_mode_i;
            end
            CMD_LOCK: begin
              st_q    <= S_LOCK;
              rmode_q <= RM_STAT;
            end
            CMD_RD_STAT:  rmode_q <= RM_STAT;
            CMD_RD_ARRAY: rmode_q <= RM_ARRAY;
            CMD_CLR_STAT: begin
              sr_seq_q <= 1'b0;
              sr_pgm_q <= 1'b0;
              sr_lck_q <= 1'b0;
              rmode_q  <= RM_ARRAY;
            end
            default: ;
          endcase
        end
        S_CNT: begin
          if (cnt_ok) begin
            st_q   <= S_DATA;
            last_q <= cnt_val[IW-1:0];
            idx_q  <= '0;
          end else begin
            st_q     <= S_IDLE;
            rmode_q  <= RM_STAT;
            sr_pgm_q <= 1'b1;
          end
        end
        S_DATA: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == last_q) st_q <= S_CONF;
        end
        S_CONF: begin
          st_q    <= S_IDLE;
          rmode_q <= RM_STAT;
          if (cmd != CMD_CONFIRM) begin
            sr_seq_q <= 1'b1;
            sr_pgm_q <= 1'b1;
          end else if (lock_q[blk_q]) begin
            sr_pgm_q <= 1'b1;
            sr_lck_q <= 1'b1;
          end
        end
        S_PGM: begin
          st_q <= S_IDLE;
          if (lock_q[blk_a]) begin
            sr_pgm_q <= 1'b1;
            sr_lck_q <= 1'b1;
          end
        end
        S_LOCK: begin
          st_q <= S_IDLE;
          if (cmd == CMD_LOCK_SET)     lock_q[blk_a] <= 1'b1;
          else if (cmd == CMD_CONFIRM) lock_q <= '0;
          else begin
            sr_seq_q <= 1'b1;
            sr_pgm_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  fcu_buffer #(.AW(AW), .DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (buf_we),
    .wr_idx_i  (buf_idx),
    .wr_addr_i (addr_i),
    .wr_data_i (wdata_i),
    .rd_idx_i  (wsm_idx),
    .rd_addr_o (buf_raddr),
    .rd_data_o (buf_rdata)
  );

  fcu_wsm #(.IW(IW), .LAT(LAT)) u_wsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wsm_start),
    .last_i  ((st_q == S_PGM) ? '0 : last_q),
    .busy_o  (wsm_busy),
    .wr_en_o (wsm_wr),
    .idx_o   (wsm_idx)
  );

  fcu_array #(.AW(AW)) u_arr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (wsm_wr),
    .waddr_i     (buf_raddr),
    .wdata_i     (buf_rdata),
    .byte_only_i (bmode_q),
    .raddr_i     (addr_i),
    .rdata_o     (arr_rdata)
  );

  assign sr = {~wsm_busy, 1'b0, sr_seq_q, sr_pgm_q, 2'b00, sr_lck_q, 1'b0};

  always_comb begin
    if (wsm_busy) begin
      rdata_o    = {8'h00, sr};
      rdata_oe_o = 16'h0080;
    end else begin
      rdata_oe_o = word_mode_i ? 16'hFFFF : 16'h00FF;
      unique case (rmode_q)
        RM_ARRAY: rdata_o = word_mode_i ? arr_rdata : {8'h00, arr_rdata[7:0]};
        RM_STAT:  rdata_o = {8'h00, sr};
        default:  rdata_o = 16'h0080;
      endcase
    end
  end

  AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsm_busy && we_i) |=> $stable(st_q) && $stable(rmode_q) && $stable(lock_q)); // R7
  AST_START_NEEDS_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wsm_busy) |-> $past(we_i) && (($past(st_q) == S_PGM) ||
      (($past(st_q) == S_CONF) && ($past(wdata_i[7:0]) == CMD_CONFIRM)))); // R3
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_we && st_q == S_CNT && !cnt_ok) |=> sr_pgm_q && (st_q == S_IDLE)); // R4
  AST_LOCK_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_we && st_q == S_PGM && lock_q[blk_a]) |=> !wsm_busy && sr_lck_q); // R8
  AST_CLR_ALL_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_we && st_q == S_LOCK && cmd == CMD_CONFIRM) |=> lock_q == '0); // R9
endmodule

// File: tb/sim_flash_wbuf_cui.sv
module sim_flash_wbuf_cui;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        word_mode_i = 1'b1;
  logic [15:0] rdata_o, rdata_oe_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [15:0] q_d[$];
  logic [15:0] q_oe[$];
  string       q_tag[$];

  always #5 clk_i = ~clk_i;

  flash_wbuf_cui u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .word_mode_i(word_mode_i),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  // driver side: set address, queue expectation; monitor compares after next edge
  task automatic rd(input logic [5:0] a, input logic [15:0] d, input logic [15:0] oe, input string tag);
    addr_i = a;
    q_d.push_back(d); q_oe.push_back(oe); q_tag.push_back(tag);
    @(negedge clk_i);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400; i++) begin
      if (rdata_o[7]) break;
      @(negedge clk_i);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      while (q_d.size() > 0) begin
        logic [15:0] ed, eo;
        string t;
        ed = q_d.pop_front(); eo = q_oe.pop_front(); t = q_tag.pop_front();
        vectors++;
        if (rdata_oe_o !== eo || (rdata_o & eo) !== (ed & eo)) begin
          miscompares++;
          $display("FAIL %s: got data %h oe %h, expected data %h oe %h", t, rdata_o & rdata_oe_o, rdata_oe_o, ed & eo, eo);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(6'h00, 16'hFFFF, 16'hFFFF, "R1 array erased");
    rd(6'h3F, 16'hFFFF, 16'hFFFF, "R1 array erased top");
    wr(6'h00, 16'h0070);
    rd(6'h00, 16'h0080, 16'hFFFF, "R1 R10 status after reset");

    // R2 buffered program, N=2, with D0h as a data value (R3)
    wr(6'h10, 16'h00E8);
    rd(6'h10, 16'h0080, 16'hFFFF, "R2 extended status");
    wr(6'h10, 16'h0002);
    wr(6'h10, 16'hAAAA);
    wr(6'h11, 16'h00D0);
    wr(6'h12, 16'h5555);
    wr(6'h10, 16'h00D0);
    rd(6'h10, 16'h0000, 16'h0080, "R7 busy mask");
    wr(6'h00, 16'h00FF);
    wait_ready();
    rd(6'h00, 16'h0080, 16'hFFFF, "R7 write during busy ignored");
    wr(6'h00, 16'h00FF);
    rd(6'h10, 16'hAAAA, 16'hFFFF, "R2 word 0");
    rd(6'h11, 16'h00D0, 16'hFFFF, "R3 D0 stored as data");
    rd(6'h12, 16'h5555, 16'hFFFF, "R2 word 2");
    rd(6'h13, 16'hFFFF, 16'hFFFF, "R2 beyond N+1 untouched");

    // R3 wrong confirm aborts
    wr(6'h20, 16'h00E8);
    wr(6'h20, 16'h0001);
    wr(6'h20, 16'h1111);
    wr(6'h21, 16'h2222);
    wr(6'h20, 16'h00FF);
    rd(6'h20, 16'h00B0, 16'hFFFF, "R3 abort status");
    wr(6'h20, 16'h0050);
    rd(6'h20, 16'hFFFF, 16'hFFFF, "R3 R10 array unchanged after abort");

    // R4 word count limit
    wr(6'h20, 16'h00E8);
    wr(6'h20, 16'h0010);
    rd(6'h20, 16'h0090, 16'hFFFF, "R4 word count over limit");
    wr(6'h20, 16'h00FF);
    rd(6'h20, 16'hFFFF, 16'hFFFF, "R4 next write decoded as command");
    wr(6'h20, 16'h0050);
    wr(6'h30, 16'h00E8);
    wr(6'h30, 16'h000F);
    for (int i = 0; i < 16; i++) wr(6'(6'h30 + i), 16'h3000 + 16'(i));
    wr(6'h30, 16'h00D0);
    wait_ready();
    rd(6'h30, 16'h0080, 16'hFFFF, "R4 max word count accepted");
    wr(6'h30, 16'h00FF);
    rd(6'h30, 16'h3000, 16'hFFFF, "R4 first of 16");
    rd(6'h3F, 16'h300F, 16'hFFFF, "R4 last of 16");

    // R5 R6 single program, upper command byte ignored
    wr(6'h08, 16'h1240);
    wr(6'h08, 16'hBEEF);
    wait_ready();
    rd(6'h08, 16'h0080, 16'hFFFF, "R6 program status clean");
    wr(6'h08, 16'h55FF);
    rd(6'h08, 16'hBEEF, 16'hFFFF, "R5 R6 program via 40h");
    wr(6'h09, 16'h0010);
    wr(6'h09, 16'hCAFE);
    wait_ready();
    wr(6'h09, 16'h00FF);
    rd(6'h09, 16'hCAFE, 16'hFFFF, "R6 program via 10h");

    // R8 locks
    wr(6'h00, 16'h0060);
    wr(6'h00, 16'h0001);
    wr(6'h02, 16'h0040);
    wr(6'h02, 16'h1357);
    rd(6'h02, 16'h0092, 16'hFFFF, "R8 program to locked block");
    wr(6'h02, 16'h0050);
    rd(6'h02, 16'hFFFF, 16'hFFFF, "R8 locked word unchanged");
    wr(6'h04, 16'h00E8);
    wr(6'h04, 16'h0000);
    wr(6'h04, 16'h2468);
    wr(6'h04, 16'h00D0);
    rd(6'h04, 16'h0092, 16'hFFFF, "R8 buffer to locked block");
    wr(6'h04, 16'h0050);
    rd(6'h04, 16'hFFFF, 16'hFFFF, "R8 buffer target unchanged");

    // R9 clear all locks
    wr(6'h10, 16'h0060);
    wr(6'h10, 16'h0001);
    wr(6'h00, 16'h0060);
    wr(6'h00, 16'h00D0);
    rd(6'h00, 16'h0080, 16'hFFFF, "R9 clear status");
    wr(6'h03, 16'h0040);
    wr(6'h03, 16'h7777);
    wait_ready();
    wr(6'h13, 16'h0040);
    wr(6'h13, 16'h8888);
    wait_ready();
    rd(6'h13, 16'h0080, 16'hFFFF, "R9 no lock error");
    wr(6'h00, 16'h00FF);
    rd(6'h03, 16'h7777, 16'hFFFF, "R9 block 0 unlocked");
    rd(6'h13, 16'h8888, 16'hFFFF, "R9 block 1 unlocked");

    // byte mode
    word_mode_i = 1'b0;
    rd(6'h31, 16'h0001, 16'h00FF, "R5 R10 byte read");
    wr(6'h20, 16'h00E8);
    wr(6'h20, 16'h0020);
    rd(6'h20, 16'h0090, 16'h00FF, "R4 byte count over limit");
    wr(6'h20, 16'h0050);
    wr(6'h20, 16'h00E8);
    wr(6'h20, 16'h011F);
    for (int i = 0; i < 32; i++) wr(6'(6'h20 + i), {8'hEE, 8'(8'h40 + i)});
    wr(6'h20, 16'hAAD0);
    wait_ready();
    rd(6'h20, 16'h0080, 16'h00FF, "R4 max byte count accepted");
    wr(6'h20, 16'h00FF);
    rd(6'h20, 16'h0040, 16'h00FF, "R5 byte low read");
    word_mode_i = 1'b1;
    rd(6'h20, 16'hFF40, 16'hFFFF, "R5 upper byte kept");
    rd(6'h3F, 16'h305F, 16'hFFFF, "R5 byte 32 merged");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule